// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks the elements of one vector operation in which the source operand and the destination operand each carry a predicate of their own. Both predicates come from a single mask value. Either side may see that value inverted, under its own flag. A source step counter and a destination step counter start from values loaded at launch, so a loop that was cut short can be resumed from the saved steps. Each counter moves forward past elements whose predicate bit is clear, independently of the other. When both counters rest on enabled elements, the block offers one element pair to an execution stage. The pair carries the register indices `base + step` for each side.

The execution stage included here reads the source register and sign-extends its low byte to the full register width. It writes the result to the destination register on the handshake. A small register file with a load port and a read port stands in for the machine's register file. Destination registers of skipped elements are never written. The loop ends as soon as either counter reaches the vector length. At that point both counters return to zero and a one-cycle done pulse is raised. The live counters are visible at the ports throughout, so the loop state can be saved if the loop is interrupted.

Top module: `vec_pred_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is reset: `busy`, `done` and `iss_valid` are 0 and both step outputs are 0.
- R2: A `start` seen while idle captures the vector length, mask, invert flags and bases, loads `src_step`/`dst_step` from the init inputs, and sets `busy`. A `start` seen while busy has no effect.
- R3: Bit i of `mask` is the predicate of element i. The source predicate is `mask[i] ^ src_inv` and the destination predicate is `mask[i] ^ dst_inv`. A value of 1 means the element is enabled.
- R4: In every busy cycle that does not end the loop and does not offer a pair, each side whose current element is disabled advances its step by one. Both sides advance in the same cycle when both are disabled.
- R5: `iss_valid` is 1 exactly when the block is busy, both steps are below the effective length, and both current elements are enabled. The indices are then `src_base + src_step` and `dst_base + dst_step`, each taken modulo the register count (16).
- R6: While `iss_valid` is 1 and `iss_ready` is 0, the offered pair and both steps stay unchanged. When both are 1, both steps advance by one.
- R7: The loop ends in the first busy cycle in which either step is at or above the effective length, which is `min(vl, MAXVL)`. No pair is offered in that cycle. On the next edge both steps become 0, `busy` falls, and `done` is 1 for exactly one cycle.
- R8: Elements below the starting steps are never examined. A starting step at or above the effective length ends the loop without offering a pair.
- R9: On each handshake, the destination register receives the source register's bits [7:0] sign-extended to 64 bits. For example, 0x92 becomes 0xFFFF_FFFF_FFFF_FF92.
- R10: Destination registers of elements that were skipped, or that lie outside the processed range, keep their previous contents.
- R11: `ld_we` writes `ld_data` to register `ld_addr` at the clock edge unless an element write happens in the same cycle. `rd_data` shows register `rd_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch the loop (ignored while busy) |
| vl | input | 4 | Vector length |
| src_step_init | input | 4 | Saved source step to resume from |
| dst_step_init | input | 4 | Saved destination step to resume from |
| mask | input | 8 | Predicate mask value, bit i for element i |
| src_inv | input | 1 | Invert the mask for the source side |
| dst_inv | input | 1 | Invert the mask for the destination side |
| src_base | input | 4 | Source vector base register |
| dst_base | input | 4 | Destination vector base register |
| iss_ready | input | 1 | Execution stage accepts the offered pair |
| iss_valid | output | 1 | An element pair is offered |
| iss_src_idx | output | 4 | Source register index of the offered pair |
| iss_dst_idx | output | 4 | Destination register index of the offered pair |
| src_step | output | 4 | Live source step counter |
| dst_step | output | 4 | Live destination step counter |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle pulse after the loop ends |
| ld_we | input | 1 | Register load enable |
| ld_addr | input | 4 | Register load address |
| ld_data | input | 64 | Register load data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 64 | Register read data |

## Verification
Two pairs of behaviours can coincide. The source skip and the destination skip can fall in the same cycle. The last handshake can also be directly followed by the end of the loop. The bench sweeps every 4-bit mask pattern, both invert flags, starting steps 0 to 4 and several lengths, so both sides often begin on disabled elements together. It compares the cycle of the done pulse with a bench model in which each busy cycle costs one step, whether it skips or issues, plus one cycle per stalled offer. A mismatch there exposes a side that waited for the other instead of advancing alongside it. The order of the offered pairs and the final contents of the destination registers judge the rest.

// File: rtl/vps_pkg.sv
// Shared types for the twin-predicated vector element sequencer.
// Assumes nothing beyond a single clock domain.
package vps_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int N_SIDES  = 2;

endpackage

// File: rtl/vps_pred_unit.sv
// Predicate lookup for one operand side.
// Reports whether the step is still inside the loop (live) and whether the
// element at that step is enabled (ok). Assumes lim <= MAXVL.
module vps_pred_unit #(
    parameter int MAXVL = 8,
    parameter int SW    = 4
) (
    input  logic [MAXVL-1:0] mask,
    input  logic             inv,
    input  logic [SW-1:0]    step,
    input  logic [SW-1:0]    lim,
    output logic             live,
    output logic             ok
);
    localparam int IW = (MAXVL > 1) ? $clog2(MAXVL) : 1;

    logic bit_raw;

    // Pick the mask bit for this step, guarding against indices past MAXVL.
    always_comb begin
        bit_raw = 1'b0;
        if (step < SW'(MAXVL)) begin
            bit_raw = mask[step[IW-1:0]];
        end
        live = (step < lim);
        ok   = live && (bit_raw ^ inv);
    end

endmodule

// File: rtl/vps_step_ctrl.sv
// Step sequencer: holds the captured loop configuration, both step counters
// and the run state. Advances each side past disabled elements, offers a pair
// when both sides are enabled, and ends the loop when either side runs out.
// Assumes NREG is a power of two (indices wrap modulo NREG).
module vps_step_ctrl
    import vps_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int SW    = 4,
    parameter int RW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SW-1:0]    vl,
    input  logic [SW-1:0]    src_step_init,
    input  logic [SW-1:0]    dst_step_init,
    input  logic [MAXVL-1:0] mask,
    input  logic             src_inv,
    input  logic             dst_inv,
    input  logic [RW-1:0]    src_base,
    input  logic [RW-1:0]    dst_base,
    input  logic             src_live,
    input  logic             src_ok,
    input  logic             dst_live,
    input  logic             dst_ok,
    input  logic             iss_ready,
    output logic [MAXVL-1:0] mask_q,
    output logic             src_inv_q,
    output logic             dst_inv_q,
    output logic [SW-1:0]    lim_q,
    output logic [SW-1:0]    src_step,
    output logic [SW-1:0]    dst_step,
    output logic             busy,
    output logic             done,
    output logic             iss_valid,
    output logic [RW-1:0]    iss_src_idx,
    output logic [RW-1:0]    iss_dst_idx
);
    seq_state_e       state;
    logic [RW-1:0]    src_base_q;
    logic [RW-1:0]    dst_base_q;
    logic             loop_end;
    logic             pair_ok;
    logic [SW-1:0]    lim_in;

    // Clamp the requested length to the largest supported vector.
    assign lim_in = (vl > SW'(MAXVL)) ? SW'(MAXVL) : vl;

    // Decode end-of-loop, pair availability and the offered indices.
    always_comb begin
        busy        = (state == SEQ_RUN);
        loop_end    = busy && !(src_live && dst_live);
        pair_ok     = src_ok && dst_ok;
        iss_valid   = busy && !loop_end && pair_ok;
        iss_src_idx = RW'(src_base_q + RW'(src_step));
        iss_dst_idx = RW'(dst_base_q + RW'(dst_step));
    end

    // State, configuration capture and step advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            src_step   <= '0;
            dst_step   <= '0;
            done       <= 1'b0;
            mask_q     <= '0;
            src_inv_q  <= 1'b0;
            dst_inv_q  <= 1'b0;
            lim_q      <= '0;
            src_base_q <= '0;
            dst_base_q <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state      <= SEQ_RUN;
                        src_step   <= src_step_init;
                        dst_step   <= dst_step_init;
                        mask_q     <= mask;
                        src_inv_q  <= src_inv;
                        dst_inv_q  <= dst_inv;
                        lim_q      <= lim_in;
                        src_base_q <= src_base;
                        dst_base_q <= dst_base;
                    end
                end
                default: begin
                    if (loop_end) begin
                        state    <= SEQ_IDLE;
                        src_step <= '0;
                        dst_step <= '0;
                        done     <= 1'b1;
                    end else if (pair_ok) begin
                        if (iss_ready) begin
                            src_step <= src_step + 1'b1;
                            dst_step <= dst_step + 1'b1;
                        end
                    end else begin
                        if (!src_ok) src_step <= src_step + 1'b1;
                        if (!dst_ok) dst_step <= dst_step + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/vps_elem_exec.sv
// Element execution stage: on a handshake, sign-extends the source byte and
// requests a write of the result to the destination register in the same
// cycle. Purely combinational; assumes the register file reads without delay.
module vps_elem_exec #(
    parameter int XLEN = 64,
    parameter int RW   = 4
) (
    input  logic            iss_valid,
    input  logic            iss_ready,
    input  logic [RW-1:0]   iss_dst_idx,
    input  logic [7:0]      src_byte,
    output logic            ex_we,
    output logic [RW-1:0]   ex_addr,
    output logic [XLEN-1:0] ex_data
);
    // Form the write request from the accepted pair.
    always_comb begin
        ex_we   = iss_valid && iss_ready;
        ex_addr = iss_dst_idx;
        ex_data = {{(XLEN-8){src_byte[7]}}, src_byte};
    end

endmodule

// File: rtl/vps_regfile.sv
// Small register file: one write port, one full-width read port and one
// byte-wide read port for the execution stage. Reads are combinational.
module vps_regfile #(
    parameter int NREG = 16,
    parameter int XLEN = 64,
    parameter int RW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RW-1:0]   raddr,
    output logic [XLEN-1:0] rdata,
    input  logic [RW-1:0]   baddr,
    output logic [7:0]      bdata
);
    logic [XLEN-1:0] regs [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_row
            // Clear on reset, update when this row is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (we && (waddr == RW'(g))) begin
                    regs[g] <= wdata;
                end
            end
        end
    endgenerate

    // Combinational read ports.
    always_comb begin
        rdata = regs[raddr];
        bdata = regs[baddr][7:0];
    end

endmodule

// File: rtl/vec_pred_seq.sv
// Twin-predicated vector element sequencer top. Connects the step sequencer,
// one predicate unit per operand side, the sign-extend execution stage and
// the register file. Element writes take priority over the load port.
// Assumes NREG is a power of two and MAXVL fits in the step width.
module vec_pred_seq #(
    parameter int MAXVL = 8,
    parameter int NREG  = 16,
    parameter int XLEN  = 64,
    parameter int SW    = $clog2(MAXVL + 1),
    parameter int RW    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SW-1:0]    vl,
    input  logic [SW-1:0]    src_step_init,
    input  logic [SW-1:0]    dst_step_init,
    input  logic [MAXVL-1:0] mask,
    input  logic             src_inv,
    input  logic             dst_inv,
    input  logic [RW-1:0]    src_base,
    input  logic [RW-1:0]    dst_base,
    input  logic             iss_ready,
    output logic             iss_valid,
    output logic [RW-1:0]    iss_src_idx,
    output logic [RW-1:0]    iss_dst_idx,
    output logic [SW-1:0]    src_step,
    output logic [SW-1:0]    dst_step,
    output logic             busy,
    output logic             done,
    input  logic             ld_we,
    input  logic [RW-1:0]    ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [RW-1:0]    rd_addr,
    output logic [XLEN-1:0]  rd_data
);
    import vps_pkg::*;

    logic [MAXVL-1:0]        mask_q;
    logic                    src_inv_q;
    logic                    dst_inv_q;
    logic [SW-1:0]           lim_q;
    logic [N_SIDES-1:0]      side_inv;
    logic [SW-1:0]           side_step [N_SIDES];
    logic [N_SIDES-1:0]      side_live;
    logic [N_SIDES-1:0]      side_ok;
    logic                    ex_we;
    logic [RW-1:0]           ex_addr;
    logic [XLEN-1:0]         ex_data;
    logic [7:0]              src_byte;
    logic                    rf_we;
    logic [RW-1:0]           rf_waddr;
    logic [XLEN-1:0]         rf_wdata;

    // Gather per-side inputs for the predicate units.
    always_comb begin
        side_inv[SIDE_SRC]  = src_inv_q;
        side_inv[SIDE_DST]  = dst_inv_q;
        side_step[SIDE_SRC] = src_step;
        side_step[SIDE_DST] = dst_step;
    end

    vps_step_ctrl #(.MAXVL(MAXVL), .SW(SW), .RW(RW)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .vl            (vl),
        .src_step_init (src_step_init),
        .dst_step_init (dst_step_init),
        .mask          (mask),
        .src_inv       (src_inv),
        .dst_inv       (dst_inv),
        .src_base      (src_base),
        .dst_base      (dst_base),
        .src_live      (side_live[SIDE_SRC]),
        .src_ok        (side_ok[SIDE_SRC]),
        .dst_live      (side_live[SIDE_DST]),
        .dst_ok        (side_ok[SIDE_DST]),
        .iss_ready     (iss_ready),
        .mask_q        (mask_q),
        .src_inv_q     (src_inv_q),
        .dst_inv_q     (dst_inv_q),
        .lim_q         (lim_q),
        .src_step      (src_step),
        .dst_step      (dst_step),
        .busy          (busy),
        .done          (done),
        .iss_valid     (iss_valid),
        .iss_src_idx   (iss_src_idx),
        .iss_dst_idx   (iss_dst_idx)
    );

    generate
        for (genvar s = 0; s < N_SIDES; s++) begin : g_side
            vps_pred_unit #(.MAXVL(MAXVL), .SW(SW)) i_pred (
                .mask (mask_q),
                .inv  (side_inv[s]),
                .step (side_step[s]),
                .lim  (lim_q),
                .live (side_live[s]),
                .ok   (side_ok[s])
            );
        end
    endgenerate

    vps_elem_exec #(.XLEN(XLEN), .RW(RW)) i_exec (
        .iss_valid   (iss_valid),
        .iss_ready   (iss_ready),
        .iss_dst_idx (iss_dst_idx),
        .src_byte    (src_byte),
        .ex_we       (ex_we),
        .ex_addr     (ex_addr),
        .ex_data     (ex_data)
    );

    // Arbitrate the single write port: element results win over loads.
    always_comb begin
        rf_we    = ex_we || ld_we;
        rf_waddr = ex_we ? ex_addr : ld_addr;
        rf_wdata = ex_we ? ex_data : ld_data;
    end

    vps_regfile #(.NREG(NREG), .XLEN(XLEN), .RW(RW)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data),
        .baddr (iss_src_idx),
        .bdata (src_byte)
    );

endmodule

// File: rtl/vps_checker.sv
// Protocol and sequencing properties for vec_pred_seq, attached by bind.
module vps_checker #(
    parameter int SW = 4,
    parameter int RW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic [RW-1:0] iss_src_idx,
    input logic [RW-1:0] iss_dst_idx,
    input logic [SW-1:0] src_step,
    input logic [SW-1:0] dst_step,
    input logic          ex_we
);

    p_valid_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> busy);

    p_hold_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_src_idx)
                                       && $stable(iss_dst_idx)));

    p_hold_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> ($stable(src_step) && $stable(dst_step)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && src_step == '0 && dst_step == '0));

    p_write_on_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ex_we |-> (iss_valid && iss_ready));

endmodule

bind vec_pred_seq vps_checker #(.SW(SW), .RW(RW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .iss_valid   (iss_valid),
    .iss_ready   (iss_ready),
    .iss_src_idx (iss_src_idx),
    .iss_dst_idx (iss_dst_idx),
    .src_step    (src_step),
    .dst_step    (dst_step),
    .ex_we       (ex_we)
);

// File: tb/test_vec_pred_seq.sv
module test_vec_pred_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  vl = '0;
    logic [3:0]  src_step_init = '0;
    logic [3:0]  dst_step_init = '0;
    logic [7:0]  mask = '0;
    logic        src_inv = 1'b0;
    logic        dst_inv = 1'b0;
    logic [3:0]  src_base = '0;
    logic [3:0]  dst_base = '0;
    logic        iss_ready = 1'b0;
    logic        iss_valid;
    logic [3:0]  iss_src_idx;
    logic [3:0]  iss_dst_idx;
    logic [3:0]  src_step;
    logic [3:0]  dst_step;
    logic        busy;
    logic        done;
    logic        ld_we = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [63:0] ld_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] mem [16];

    always #5 clk = ~clk;

    vec_pred_seq i_vec_pred_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .src_step_init(src_step_init), .dst_step_init(dst_step_init),
        .mask(mask), .src_inv(src_inv), .dst_inv(dst_inv),
        .src_base(src_base), .dst_base(dst_base), .iss_ready(iss_ready),
        .iss_valid(iss_valid), .iss_src_idx(iss_src_idx),
        .iss_dst_idx(iss_dst_idx), .src_step(src_step), .dst_step(dst_step),
        .busy(busy), .done(done), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sext8(input logic [63:0] v);
        return {{56{v[7]}}, v[7:0]};
    endfunction

    // Load one register through the load port (R11) and mirror it.
    task automatic load_reg(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(posedge clk);
        #1 ld_we = 1'b0;
        mem[a] = d;
    endtask

    task automatic run_case(input int vli, input logic [7:0] m, input logic si,
                            input logic di, input int ss, input int ds,
                            input bit stall, input logic [3:0] sb,
                            input logic [3:0] db);
        int es [8];
        int ed [8];
        int ne = 0;
        int iters = 0;
        int s = ss;
        int d = ds;
        int lim = (vli > 8) ? 8 : vli;
        int n = 0;
        int got = 0;
        int stalls = 0;
        logic [63:0] exp_mem [16];
        // Bench model of the loop (R3, R4, R7, R8).
        while (s < lim && d < lim) begin
            bit ps = m[s] ^ si;
            bit pd = m[d] ^ di;
            if (ps && pd) begin
                es[ne] = s; ed[ne] = d; ne++;
                s++; d++;
            end else begin
                if (!ps) s++;
                if (!pd) d++;
            end
            iters++;
        end
        for (int i = 0; i < 16; i++) exp_mem[i] = mem[i];
        for (int k = 0; k < ne; k++)
            exp_mem[4'(db + 4'(ed[k]))] = sext8(mem[4'(sb + 4'(es[k]))]);

        @(negedge clk);
        vl = 4'(vli); mask = m; src_inv = si; dst_inv = di;
        src_step_init = 4'(ss); dst_step_init = 4'(ds);
        src_base = sb; dst_base = db; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        // Starting steps are visible once loaded (R2).
        check(busy && src_step == 4'(ss) && dst_step == 4'(ds), "R2 load",
              {src_step, dst_step}, {4'(ss), 4'(ds)});
        while (n < 60) begin
            iss_ready = stall ? (((n * 5 + ss + ds) % 3) != 0) : 1'b1;
            #1;
            if (done) break;
            if (iss_valid) begin
                if (iss_ready) begin
                    if (got < ne) begin
                        check(iss_src_idx == 4'(sb + 4'(es[got])), "R5 src idx",
                              64'(iss_src_idx), 64'(4'(sb + 4'(es[got]))));
                        check(iss_dst_idx == 4'(db + 4'(ed[got])), "R5 dst idx",
                              64'(iss_dst_idx), 64'(4'(db + 4'(ed[got]))));
                    end
                    got++;
                end else begin
                    stalls++;
                end
            end
            // A start pulse while busy must have no effect (R2).
            if (stall && n == 1) begin
                start = 1'b1; src_step_init = 4'd0; dst_step_init = 4'd0;
                mask = ~m;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        iss_ready = 1'b0;
        // Both-sided skip per cycle fixes the cycle of the done pulse (R4, R7).
        check(done && n == iters + stalls + 1, "R4 R7 done cycle",
              64'(n), 64'(iters + stalls + 1));
        check(ne == got, "R5 R8 pair count", 64'(got), 64'(ne));
        check(!busy && src_step == 0 && dst_step == 0, "R7 end state",
              {busy, src_step, dst_step}, 64'h0);
        for (int i = 0; i < 6; i++) begin
            logic [3:0] a = 4'(db + 4'(i));
            rd_addr = a;
            #1;
            check(rd_data == exp_mem[a], "R9 R10 dest reg", rd_data, exp_mem[a]);
        end
        for (int i = 0; i < 16; i++) mem[i] = exp_mem[i];
        @(negedge clk);
        check(!done, "R7 done pulse width", 64'(done), 64'h0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !iss_valid && src_step == 0 && dst_step == 0,
              "R1 reset", {busy, done, iss_valid, src_step, dst_step}, 64'h0);
        rst_n = 1'b1;

        // Directed resume case: one pair, source element 2 to destination 3.
        for (int i = 0; i < 4; i++) load_reg(4'(9 + i), 64'h90 + 64'(i));
        for (int i = 0; i < 4; i++) load_reg(4'(5 + i), 64'h0);
        run_case(4, 8'h05, 1'b0, 1'b1, 1, 2, 1'b0, 4'd9, 4'd5);
        rd_addr = 4'd8;
        #1;
        check(rd_data == 64'hFFFF_FFFF_FFFF_FF92, "R9 directed r8", rd_data,
              64'hFFFF_FFFF_FFFF_FF92);
        rd_addr = 4'd6;
        #1;
        check(rd_data == 64'h0, "R10 directed r6", rd_data, 64'h0);

        // Sweep: lengths, all 4-bit masks, invert flags, start steps 0..4.
        for (int i = 0; i < 5; i++)
            load_reg(4'(9 + i), 64'hA5A5_0000_0000_0000 | 64'(8'(32 + i * 91)));
        for (int vi = 0; vi < 3; vi++) begin
            for (int m4 = 0; m4 < 16; m4++) begin
                for (int iv = 0; iv < 4; iv++) begin
                    for (int ss = 0; ss < 5; ss++) begin
                        for (int ds = 0; ds < 5; ds++) begin
                            int vli = (vi == 0) ? 2 : ((vi == 1) ? 4 : 5);
                            logic [7:0] m8 = {4'(m4) ^ 4'hA, 4'(m4)};
                            bit stall = ((ss + ds + m4 + iv) % 2) == 1;
                            for (int r = 0; r < 5; r++)
                                load_reg(4'(5 + r), 64'hDEAD_0000_0000_0000
                                         + 64'(m4 * 256 + ss * 16 + ds * 4 + r));
                            run_case(vli, m8, iv[0], iv[1], ss, ds, stall,
                                     4'd9, 4'd5);
                        end
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule